// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block decides when a simple DRAM command controller must stop serving requests so that the memory can be refreshed, and it issues the refresh commands itself. A free-running interval timer marks a refresh due point every `cfg_refi` clock edges. When a due point arrives, the block withdraws its issue grant. It then waits until the controller reports that no access is still outstanding. If any bank still has a row open, it sends a single precharge-all command and waits `cfg_rp` cycles for it to complete. After that it sends a single refresh command, waits `cfg_rfc` cycles, and gives the grant back.

To decide whether the precharge is needed, the block keeps an open-row register for every bank of every rank. The controller reports its own activates and per-bank precharges on dedicated inputs. The row code of all ones is reserved to mean that the bank is closed. The interval timer never pauses, so due points stay on a fixed grid however long the sequence takes. A due point that falls inside a sequence in progress is owed, and it starts a new sequence as soon as the current one ends.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset `issue_grant` is 1, `pre_all` and `refresh` are 0, and every bank is closed (`banks_open` is all zeros).
- R2: Counting clock edges from reset release, a due point falls on every edge whose count is a multiple of `cfg_refi`. The timer keeps counting during a sequence. The grant drops in the cycle after a due point seen while idle, and it stays low for the whole sequence.
- R3: While draining, the block stays put with the grant low and no command issued, for as long as `inflight` is nonzero on a clock edge.
- R4: On the first edge in drain with `inflight` zero, suppose some bank is open or an activate that opens a bank is presented on that edge. Then `pre_all` is high for exactly the next cycle.
- R5: `refresh` rises exactly `cfg_rp` cycles after the `pre_all` cycle. A `cfg_rp` of 0 acts as 1.
- R6: `refresh` is high for one cycle only. The grant returns in the cycle `cfg_rfc` cycles after the refresh cycle (a value of 0 acts as 1). `refresh` and `pre_all` never coincide with the grant.
- R7: When drain ends with every bank closed and no activate on that edge, no `pre_all` is issued, and `refresh` is high in the very next cycle.
- R8: Bank index `rank*NUM_BANKS+bank` of `banks_open` goes to 1 on an activate and to 0 on a per-bank precharge of that bank. An activate and a precharge to the same bank on one edge leave the bank open. An activate whose row is all ones leaves the bank closed.
- R9: The edge that ends a `pre_all` cycle closes every bank, and an activate presented on that same edge is ignored.
- R10: An activate arriving on the very edge where drain ends, with all banks closed, still forces the precharge-all path.
- R11: A due point that falls while a sequence is in progress is kept. The grant then returns for exactly one cycle before the next drain begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_refi | input | TIMER_W | Refresh interval in cycles (at least 1) |
| cfg_rp | input | TIMER_W | Precharge completion time in cycles |
| cfg_rfc | input | TIMER_W | Refresh duration in cycles |
| inflight | input | CNT_W | Count of accesses still in progress |
| act_valid | input | 1 | Controller activates a row this cycle |
| act_rank | input | RANK_W | Rank of the activate |
| act_bank | input | BANK_W | Bank of the activate |
| act_row | input | ROW_W | Row being opened |
| pre_valid | input | 1 | Controller precharges one bank this cycle |
| pre_rank | input | RANK_W | Rank of the per-bank precharge |
| pre_bank | input | BANK_W | Bank of the per-bank precharge |
| issue_grant | output | 1 | New requests may be issued |
| pre_all | output | 1 | Precharge-all command pulse |
| refresh | output | 1 | Refresh command pulse |
| banks_open | output | NUM_RANKS*NUM_BANKS | Per-bank open flag |

## Verification
The delicate coincidence is the end of drain landing on the same edge as an activate from the last outstanding access. The decision to skip the precharge must then take into account the bank that this activate is opening at that moment. The bench provokes this by closing every bank, holding `inflight` nonzero for a few drain cycles, and then dropping it to zero together with an activate. It judges the result by seeing `pre_all` rather than `refresh` in the next cycle. A second coincidence, a timer due point landing inside a running sequence, is forced with a short interval and a long drain. It is judged by the single grant cycle that separates the two sequences.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_DRAIN = 2'd1,
      RS_PRE   = 2'd2,
      RS_RUN   = 2'd3
   } ref_state_e;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIMER_W-1:0] cfg_refi,
   output logic               due
);

   logic [TIMER_W-1:0] elapsed_q;
   logic [TIMER_W:0]   elapsed_p1;

   assign elapsed_p1 = {1'b0, elapsed_q} + {{TIMER_W{1'b0}}, 1'b1};
   assign due        = (elapsed_p1 >= {1'b0, cfg_refi});

   // Free running: wraps on every due point, never held by the sequence.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elapsed_q <= '0;
      end else if (due) begin
         elapsed_q <= '0;
      end else begin
         elapsed_q <= elapsed_p1[TIMER_W-1:0];
      end
   end

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
   parameter int NUM_RANKS = 2,
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 10,
   localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int NB       = NUM_RANKS * NUM_BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_valid,
   input  logic [RANK_W-1:0] act_rank,
   input  logic [BANK_W-1:0] act_bank,
   input  logic [ROW_W-1:0]  act_row,
   input  logic              pre_valid,
   input  logic [RANK_W-1:0] pre_rank,
   input  logic [BANK_W-1:0] pre_bank,
   input  logic              close_all,
   output logic [NB-1:0]     open_mask
);

   localparam logic [ROW_W-1:0] NO_ROW = '1;

   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam int IDX = r * NUM_BANKS + b;
         logic [ROW_W-1:0] row_q;
         logic             act_hit;
         logic             pre_hit;

         assign act_hit = act_valid && (act_rank == RANK_W'(r)) && (act_bank == BANK_W'(b));
         assign pre_hit = pre_valid && (pre_rank == RANK_W'(r)) && (pre_bank == BANK_W'(b));

         // close_all outranks everything; an activate outranks a single precharge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_q <= NO_ROW;
            end else if (close_all) begin
               row_q <= NO_ROW;
            end else if (act_hit) begin
               row_q <= act_row;
            end else if (pre_hit) begin
               row_q <= NO_ROW;
            end
         end

         assign open_mask[IDX] = (row_q != NO_ROW);
      end
   end

endmodule

// File: rtl/ref_sequencer.sv
module ref_sequencer #(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               due,
   input  logic               drained,
   input  logic               need_pre,
   input  logic [TIMER_W-1:0] cfg_rp,
   input  logic [TIMER_W-1:0] cfg_rfc,
   output logic               grant,
   output logic               pre_all_q,
   output logic               ref_q
);
   import refseq_pkg::*;

   ref_state_e         state_q;
   logic               owed_q;
   logic [TIMER_W-1:0] wait_q;
   logic [TIMER_W-1:0] rp_m1;
   logic [TIMER_W-1:0] rfc_m1;

   assign rp_m1  = (cfg_rp  == '0) ? '0 : cfg_rp  - 1'b1;
   assign rfc_m1 = (cfg_rfc == '0) ? '0 : cfg_rfc - 1'b1;
   assign grant  = (state_q == RS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RS_IDLE;
         owed_q    <= 1'b0;
         wait_q    <= '0;
         pre_all_q <= 1'b0;
         ref_q     <= 1'b0;
      end else begin
         pre_all_q <= 1'b0;
         ref_q     <= 1'b0;
         case (state_q)
            RS_IDLE: begin
               if (due || owed_q) begin
                  state_q <= RS_DRAIN;
                  owed_q  <= 1'b0;
               end
            end
            RS_DRAIN: begin
               if (drained) begin
                  if (need_pre) begin
                     state_q   <= RS_PRE;
                     pre_all_q <= 1'b1;
                     wait_q    <= rp_m1;
                  end else begin
                     state_q <= RS_RUN;
                     ref_q   <= 1'b1;
                     wait_q  <= rfc_m1;
                  end
               end
            end
            RS_PRE: begin
               if (wait_q == '0) begin
                  state_q <= RS_RUN;
                  ref_q   <= 1'b1;
                  wait_q  <= rfc_m1;
               end else begin
                  wait_q <= wait_q - 1'b1;
               end
            end
            default: begin
               if (wait_q == '0) begin
                  state_q <= RS_IDLE;
               end else begin
                  wait_q <= wait_q - 1'b1;
               end
            end
         endcase
         if ((state_q != RS_IDLE) && due) begin
            owed_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
   parameter int NUM_RANKS       = 2,
   parameter int NUM_BANKS       = 4,
   parameter int ROW_W           = 10,
   parameter int TIMER_W         = 16,
   parameter int CNT_W           = 4,
   parameter bit SKIP_CLOSED_PRE = 1'b1,
   localparam int RANK_W         = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
   localparam int BANK_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int NB             = NUM_RANKS * NUM_BANKS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TIMER_W-1:0] cfg_refi,
   input  logic [TIMER_W-1:0] cfg_rp,
   input  logic [TIMER_W-1:0] cfg_rfc,
   input  logic [CNT_W-1:0]   inflight,
   input  logic               act_valid,
   input  logic [RANK_W-1:0]  act_rank,
   input  logic [BANK_W-1:0]  act_bank,
   input  logic [ROW_W-1:0]   act_row,
   input  logic               pre_valid,
   input  logic [RANK_W-1:0]  pre_rank,
   input  logic [BANK_W-1:0]  pre_bank,
   output logic               issue_grant,
   output logic               pre_all,
   output logic               refresh,
   output logic [NB-1:0]      banks_open
);

   if (NUM_RANKS < 1 || NUM_BANKS < 1) begin : g_bad_geometry
      $error("dram_refresh_seq: NUM_RANKS and NUM_BANKS must be at least 1");
   end
   if (ROW_W < 2) begin : g_bad_row
      $error("dram_refresh_seq: ROW_W must be at least 2");
   end
   if (TIMER_W < 2 || CNT_W < 1) begin : g_bad_counts
      $error("dram_refresh_seq: TIMER_W must be at least 2 and CNT_W at least 1");
   end

   logic due;
   logic drained;
   logic need_pre;
   logic opening_now;

   assign drained     = (inflight == '0);
   assign opening_now = act_valid && (act_row != '1);

   // Variant choice: skip the precharge when nothing is open, or always send it.
   if (SKIP_CLOSED_PRE) begin : g_skip_closed
      assign need_pre = (|banks_open) || opening_now;
   end else begin : g_always_pre
      assign need_pre = 1'b1;
   end

   ref_interval_timer #(.TIMER_W(TIMER_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_refi (cfg_refi),
      .due      (due)
   );

   bank_row_tracker #(
      .NUM_RANKS (NUM_RANKS),
      .NUM_BANKS (NUM_BANKS),
      .ROW_W     (ROW_W)
   ) i_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_valid (act_valid),
      .act_rank  (act_rank),
      .act_bank  (act_bank),
      .act_row   (act_row),
      .pre_valid (pre_valid),
      .pre_rank  (pre_rank),
      .pre_bank  (pre_bank),
      .close_all (pre_all),
      .open_mask (banks_open)
   );

   ref_sequencer #(.TIMER_W(TIMER_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .due       (due),
      .drained   (drained),
      .need_pre  (need_pre),
      .cfg_rp    (cfg_rp),
      .cfg_rfc   (cfg_rfc),
      .grant     (issue_grant),
      .pre_all_q (pre_all),
      .ref_q     (refresh)
   );

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
   parameter int TIMER_W = 16,
   parameter int CNT_W   = 4,
   parameter int NB      = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [TIMER_W-1:0] cfg_rp,
   input logic [CNT_W-1:0]   inflight,
   input logic               issue_grant,
   input logic               pre_all,
   input logic               refresh,
   input logic [NB-1:0]      banks_open
);

   logic [TIMER_W:0] since_pre_q;
   logic             pre_in_seq_q;
   logic [TIMER_W:0] rp_eff;

   assign rp_eff = (cfg_rp == '0) ? {{TIMER_W{1'b0}}, 1'b1} : {1'b0, cfg_rp};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_pre_q  <= '0;
         pre_in_seq_q <= 1'b0;
      end else begin
         if (pre_all) begin
            since_pre_q  <= {{TIMER_W{1'b0}}, 1'b1};
            pre_in_seq_q <= 1'b1;
         end else if (since_pre_q != '1) begin
            since_pre_q <= since_pre_q + 1'b1;
         end
         if (refresh) begin
            pre_in_seq_q <= 1'b0;
         end
      end
   end

   a_r4_pre_only_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all |-> ($past(inflight) == '0));

   a_r6_cmds_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_all || refresh) |-> !issue_grant);

   a_r6_refresh_single: assert property (@(posedge clk) disable iff (!rst_n)
      refresh |=> !refresh);

   a_r4_no_cmd_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(pre_all && refresh));

   a_r9_pre_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
      pre_all |=> (banks_open == '0));

   a_r5_rp_respected: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh && pre_in_seq_q) |-> (since_pre_q >= rp_eff));

   a_r7_closed_at_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      refresh |-> (banks_open == '0));

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
   .TIMER_W (TIMER_W),
   .CNT_W   (CNT_W),
   .NB      (NB)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_rp      (cfg_rp),
   .inflight    (inflight),
   .issue_grant (issue_grant),
   .pre_all     (pre_all),
   .refresh     (refresh),
   .banks_open  (banks_open)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

   localparam int CLK_PERIOD = 10;
   localparam int TW = 16;
   localparam int CW = 4;
   localparam int RW = 10;
   localparam int NBK = 8;
   localparam logic [RW-1:0] ONES_ROW = '1;

   localparam int PH_IDLE = 0, PH_DRAIN = 1, PH_PRE = 2, PH_RUN = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] cfg_refi = 16'd60, cfg_rp = 16'd3, cfg_rfc = 16'd5;
   logic [CW-1:0] inflight = '0;
   logic          act_valid = 1'b0;
   logic          act_rank = 1'b0;
   logic [1:0]    act_bank = '0;
   logic [RW-1:0] act_row = '0;
   logic          pre_valid = 1'b0;
   logic          pre_rank = 1'b0;
   logic [1:0]    pre_bank = '0;
   logic          issue_grant, pre_all, refresh;
   logic [NBK-1:0] banks_open;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   int ecount = 0;

   dram_refresh_seq i_dram_refresh_seq (
      .clk(clk), .rst_n(rst_n), .cfg_refi(cfg_refi), .cfg_rp(cfg_rp), .cfg_rfc(cfg_rfc),
      .inflight(inflight), .act_valid(act_valid), .act_rank(act_rank), .act_bank(act_bank),
      .act_row(act_row), .pre_valid(pre_valid), .pre_rank(pre_rank), .pre_bank(pre_bank),
      .issue_grant(issue_grant), .pre_all(pre_all), .refresh(refresh), .banks_open(banks_open)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) ecount <= rst_n ? ecount + 1 : 0;

   task automatic chk(input bit ok, input string tag, input int actual, input int expected);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", tag, actual, expected, ecount);
      end
   endtask

   function automatic int eff(input logic [TW-1:0] v);
      return (v == '0) ? 1 : int'(v);
   endfunction

   function automatic int bidx(input logic r, input logic [1:0] b);
      return int'(r) * 4 + int'(b);
   endfunction

   // reference model, stepped once per edge at the following falling edge
   int m_ph, m_t, m_next_due;
   bit m_owed;
   logic [NBK-1:0] m_mask;
   logic [CW-1:0] p_inf;
   bit p_act, p_pv, p_pre_out;
   logic p_ar, p_pr;
   logic [1:0] p_ab, p_pb;
   logic [RW-1:0] p_row;

   always @(negedge clk) begin
      if (!rst_n) begin
         m_ph = PH_IDLE; m_t = 0; m_owed = 0; m_mask = '0;
         m_next_due = int'(cfg_refi); p_pre_out = 0;
      end else if (ecount == 0) begin
         chk(issue_grant == 1'b1, "R1 grant", int'(issue_grant), 1);
         chk(pre_all == 1'b0, "R1 pre_all", int'(pre_all), 0);
         chk(refresh == 1'b0, "R1 refresh", int'(refresh), 0);
         chk(banks_open == '0, "R1 banks_open", int'(banks_open), 0);
         p_pre_out = 0;
      end else begin
         int  n, ph, nph;
         bit  due, open_before, opening, e_grant, e_pre, e_ref;
         string gtag, rtag;
         n = ecount; ph = m_ph; nph = ph;
         due = (n == m_next_due);
         if (due) m_next_due += int'(cfg_refi);
         open_before = (m_mask != '0);
         opening = p_act && (p_row != ONES_ROW);
         case (ph)
            PH_IDLE:  if (due || m_owed) begin nph = PH_DRAIN; m_owed = 0; end
            PH_DRAIN: if (p_inf == '0) begin
                         nph = (open_before || opening) ? PH_PRE : PH_RUN; m_t = n;
                      end
            PH_PRE:   if (n - m_t == eff(cfg_rp)) begin nph = PH_RUN; m_t = n; end
            default:  if (n - m_t == eff(cfg_rfc)) nph = PH_IDLE;
         endcase
         if (ph != PH_IDLE && due) m_owed = 1;
         if (p_pre_out) m_mask = '0;
         else begin
            if (p_pv) m_mask[bidx(p_pr, p_pb)] = 1'b0;
            if (opening) m_mask[bidx(p_ar, p_ab)] = 1'b1;
         end
         e_grant = (nph == PH_IDLE);
         e_pre = (ph == PH_DRAIN) && (nph == PH_PRE);
         e_ref = (ph != PH_RUN) && (nph == PH_RUN);
         gtag = (ph == PH_IDLE) ? "R2 grant" : (ph == PH_DRAIN) ? "R3 grant" :
                (ph == PH_PRE) ? "R5 grant" : "R6 grant";
         rtag = (ph == PH_PRE) ? "R5 refresh" : (ph == PH_DRAIN) ? "R7 refresh" : "R6 refresh";
         chk(issue_grant == e_grant, gtag, int'(issue_grant), int'(e_grant));
         chk(pre_all == e_pre, "R4 pre_all", int'(pre_all), int'(e_pre));
         chk(refresh == e_ref, rtag, int'(refresh), int'(e_ref));
         chk(banks_open == m_mask, "R8 banks_open", int'(banks_open), int'(m_mask));
         m_ph = nph;
         p_pre_out = pre_all;
      end
      p_inf = inflight; p_act = act_valid; p_ar = act_rank; p_ab = act_bank; p_row = act_row;
      p_pv = pre_valid; p_pr = pre_rank; p_pb = pre_bank;
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle_inputs();
      act_valid = 0; pre_valid = 0; inflight = '0;
   endtask

   task automatic do_reset(input int refi, input int rp, input int rfc);
      rst_n = 0; idle_inputs();
      cfg_refi = TW'(refi); cfg_rp = TW'(rp); cfg_rfc = TW'(rfc);
      repeat (3) step();
      rst_n = 1;
   endtask

   task automatic rnd_cycle();
      idle_inputs();
      inflight = ($urandom % 2 == 0) ? '0 : CW'($urandom % 4);
      if (issue_grant) begin
         if ($urandom % 3 == 0) begin
            act_valid = 1; act_rank = 1'($urandom); act_bank = 2'($urandom);
            act_row = RW'($urandom % 1023);
         end
         if ($urandom % 4 == 0) begin
            pre_valid = 1; pre_rank = 1'($urandom); pre_bank = 2'($urandom);
         end
      end
   endtask

   task automatic wait_grant(input bit level);
      while (issue_grant != level) begin idle_inputs(); inflight = CW'(1); step(); end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 180000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : driver
      void'($urandom(32'h1234_abcd));

      // tracker corner cases while idle (R8)
      do_reset(400, 3, 5);
      step();
      act_valid = 1; act_rank = 0; act_bank = 0; act_row = ONES_ROW; step();
      idle_inputs(); #1;
      chk(banks_open[0] == 1'b0, "R8 ones-row activate", int'(banks_open[0]), 0);
      act_valid = 1; act_rank = 1; act_bank = 0; act_row = 10'd5; step();
      idle_inputs(); #1;
      chk(banks_open[4] == 1'b1, "R8 activate opens", int'(banks_open[4]), 1);
      act_valid = 1; act_rank = 1; act_bank = 0; act_row = 10'd6;
      pre_valid = 1; pre_rank = 1; pre_bank = 0; step();
      idle_inputs(); #1;
      chk(banks_open[4] == 1'b1, "R8 activate beats precharge", int'(banks_open[4]), 1);
      pre_valid = 1; pre_rank = 1; pre_bank = 0; step();
      idle_inputs(); #1;
      chk(banks_open[4] == 1'b0, "R8 precharge closes", int'(banks_open[4]), 0);

      // activate on the final drain edge with all banks closed (R10), then R9, then skip R7
      do_reset(40, 4, 6);
      wait_grant(1'b0);
      repeat (3) begin inflight = CW'(2); step(); end
      inflight = '0; act_valid = 1; act_rank = 0; act_bank = 2; act_row = 10'd77; step();
      idle_inputs();
      chk(pre_all == 1'b1, "R10 pre_all after late activate", int'(pre_all), 1);
      chk(refresh == 1'b0, "R10 no direct refresh", int'(refresh), 0);
      act_valid = 1; act_rank = 1; act_bank = 3; act_row = 10'd9; step();
      idle_inputs(); #1;
      chk(banks_open == '0, "R9 activate ignored under pre_all", int'(banks_open), 0);
      wait_grant(1'b1);
      idle_inputs(); inflight = CW'(1);
      while (issue_grant) step();
      inflight = '0; step();
      chk(refresh == 1'b1, "R7 direct refresh", int'(refresh), 1);
      chk(pre_all == 1'b0, "R7 no pre_all", int'(pre_all), 0);
      repeat (20) step();

      // due point inside a long drain (R11)
      do_reset(14, 2, 3);
      wait_grant(1'b0);
      repeat (16) begin idle_inputs(); inflight = CW'(1); step(); end
      idle_inputs();
      while (!issue_grant) step();
      step();
      chk(issue_grant == 1'b0, "R11 owed drain starts", int'(issue_grant), 0);
      repeat (60) begin idle_inputs(); step(); end

      // random traffic, nominal timing
      do_reset(60, 3, 5);
      repeat (3000) begin rnd_cycle(); step(); end

      // zero timing values act as one (R5, R6)
      do_reset(25, 0, 0);
      repeat (600) begin rnd_cycle(); step(); end

      idle_inputs();
      repeat (2) step();
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule